// File: doc/BRIEF.md
# DDR3 Command Bus Monitor

This block watches a DDR3 command/address bus and works out which command the memory device receives on each rising clock edge. It uses the clock-enable level from the previous edge and from the current one, together with chip select, the three command strobes, the bank address and the address bus. For every decoded command it raises a one-hot code with a valid strobe and holds the bank, row and column fields, the auto-precharge request and the resolved burst length. All outputs are registered and appear one clock after the edge that sampled the bus.

Alongside the decode it keeps a model of the device: the power state (active, power-down or self-refresh), whether a four-clock data burst is still running, the burst mode last written to mode register 0, and a window after self-refresh exit in which writes are not allowed. Bus sequences that break these rules set a sticky error flag. A two-bit cause code records the first error, and only reset clears them.

The monitor is passive. It drives nothing back onto the bus and suits a chip-level checker or a controller's protocol watchdog.

Top module: `ddr3_cmd_monitor`

## Requirements
- R1: With clock enable high at the previous and current edge and chip select low, the strobe pattern {ras_n,cas_n,we_n} decodes as 000 mode register set, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 ZQ calibration. One-hot bit positions are NOP 0, deselect 1, mode set 2, refresh 3, activate 4, read 5, write 6, precharge 7, precharge-all 8, ZQ long 9, ZQ short 10, power-down entry 11, power-down exit 12, self-refresh entry 13, self-refresh exit 14.
- R2: With clock enable high at both edges, chip select high decodes as deselect, and chip select low with pattern 111 decodes as NOP. Neither one ends a running burst.
- R3: Address bit 10 selects the variant. For precharge, 1 means precharge-all and 0 means single bank. For ZQ, 1 means long and 0 means short. For read and write, cmd_ap copies bit 10.
- R4: A mode register set to bank 0 stores address bits 1:0 as the burst mode: 00 fixed 8-beat, 10 fixed 4-beat chop, 01 on-the-fly, 11 treated as fixed 8-beat. In on-the-fly mode cmd_len8 of a read or write copies address bit 12. In fixed modes bit 12 is ignored. A mode set to another bank leaves the mode unchanged. After reset the mode is fixed 8-beat.
- R5: When clock enable falls with deselect or NOP on the bus, the edge decodes as power-down entry and pwr_state becomes 01. When clock enable rises in power-down, the edge decodes as power-down exit and pwr_state returns to 00.
- R6: When clock enable falls with chip select low and pattern 001, the edge decodes as self-refresh entry and pwr_state becomes 10. When clock enable rises in self-refresh, the edge decodes as self-refresh exit and pwr_state returns to 00. While clock enable stays low, cmd_valid is 0.
- R7: A clock-enable fall with any other bus pattern, or a clock-enable rise while active, is illegal. cmd_valid stays 0 and error cause 1 is raised.
- R8: An accepted read or write holds burst_busy high for 4 clocks. A read or write sampled 1 to 3 edges after it is reported but raises error cause 2 and does not restart the burst. One sampled 4 edges after it is accepted.
- R9: A write sampled fewer than 512 edges after the self-refresh exit edge raises error cause 3. A write 512 edges after it is clean.
- R10: err_flag is sticky and err_code keeps the cause of the first error. If more than one error happens in the same cycle, cause 1 wins over 2, and 2 wins over 3. Only reset clears them.
- R11: Outputs change one clock after the sampling edge. When cmd_valid is 1, exactly one bit of cmd_onehot is set. When cmd_valid is 0, cmd_onehot is 0.
- R12: Synchronous active-high reset clears cmd_valid, cmd_onehot, burst_busy, err_flag and err_code, and sets pwr_state to 00 with the previous clock enable taken as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write enable strobe |
| ba | input | BA_W | Bank address |
| addr | input | ADDR_W | Address bus (bit 10 variant, bit 12 burst length) |
| cmd_valid | output | 1 | A command was decoded |
| cmd_onehot | output | NUM_CMD | One-hot command code |
| cmd_bank | output | BA_W | Bank of the last command |
| cmd_row | output | ADDR_W | Row field of the last command |
| cmd_col | output | COL_W | Column field of the last command |
| cmd_ap | output | 1 | Auto-precharge request |
| cmd_len8 | output | 1 | Resolved burst length: 1 is 8 beats, 0 is 4-beat chop |
| pwr_state | output | 2 | 00 active, 01 power-down, 10 self-refresh |
| burst_busy | output | 1 | A data burst is running |
| err_flag | output | 1 | Sticky protocol error |
| err_code | output | 2 | First error cause: 1 illegal, 2 burst cut, 3 write lockout |

## Verification
The decoder is driven with every strobe pattern under steady clock enable, then with each pairing of previous and current clock enable. This tells the normal commands apart from entry, exit and illegal edges that carry the same strobe pattern. Address bit 10 and bit 12 are toggled under each of the three burst modes, which separates fixed modes from on-the-fly resolution. A mode set to a bank other than 0 shows that only bank 0 is decoded. Back-to-back reads at 2 and 4 clocks, and writes 511 and 512 edges after self-refresh exit, sit on both sides of each timing boundary. Mixed errors show that the first cause stays.

// File: rtl/ddr3_mon_pkg.sv
package ddr3_mon_pkg;
  localparam int NUM_CMD = 15;

  typedef enum logic [3:0] {
    C_NOP  = 4'd0,  C_DES  = 4'd1,  C_MRS  = 4'd2,  C_REF  = 4'd3,
    C_ACT  = 4'd4,  C_RD   = 4'd5,  C_WR   = 4'd6,  C_PRE  = 4'd7,
    C_PREA = 4'd8,  C_ZQL  = 4'd9,  C_ZQS  = 4'd10, C_PDE  = 4'd11,
    C_PDX  = 4'd12, C_SRE  = 4'd13, C_SRX  = 4'd14
  } cmd_e;

  localparam logic [1:0] PWR_ACT = 2'b00;
  localparam logic [1:0] PWR_PD  = 2'b01;
  localparam logic [1:0] PWR_SR  = 2'b10;

  localparam logic [1:0] ERR_NONE    = 2'd0;
  localparam logic [1:0] ERR_ILLEGAL = 2'd1;
  localparam logic [1:0] ERR_BURST   = 2'd2;
  localparam logic [1:0] ERR_LOCK    = 2'd3;

  localparam logic [1:0] BM_BL8 = 2'b00;
  localparam logic [1:0] BM_OTF = 2'b01;
  localparam logic [1:0] BM_BC4 = 2'b10;
endpackage

// File: rtl/ddr3_cmd_decode.sv
module ddr3_cmd_decode
  import ddr3_mon_pkg::*;
(
  input  logic       cke_prev,
  input  logic       cke,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       a10,
  input  logic [1:0] pwr,
  output cmd_e       cmd,
  output logic       valid,
  output logic       illegal
);
  logic [2:0] pat;
  assign pat = {ras_n, cas_n, we_n};

  always_comb begin
    cmd     = C_NOP;
    valid   = 1'b0;
    illegal = 1'b0;
    unique case ({cke_prev, cke})
      2'b11: begin
        valid = 1'b1;
        if (cs_n) cmd = C_DES;
        else begin
          case (pat)
            3'b000:  cmd = C_MRS;
            3'b001:  cmd = C_REF;
            3'b010:  cmd = a10 ? C_PREA : C_PRE;
            3'b011:  cmd = C_ACT;
            3'b100:  cmd = C_WR;
            3'b101:  cmd = C_RD;
            3'b110:  cmd = a10 ? C_ZQL : C_ZQS;
            default: cmd = C_NOP;
          endcase
        end
      end
      2'b10: begin
        if (!cs_n && pat == 3'b001) begin
          cmd = C_SRE; valid = 1'b1;
        end else if (cs_n || pat == 3'b111) begin
          cmd = C_PDE; valid = 1'b1;
        end else illegal = 1'b1;
      end
      2'b01: begin
        if (pwr == PWR_SR) begin
          cmd = C_SRX; valid = 1'b1;
        end else if (pwr == PWR_PD) begin
          cmd = C_PDX; valid = 1'b1;
        end else illegal = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ddr3_pwr_track.sv
module ddr3_pwr_track
  import ddr3_mon_pkg::*;
#(
  parameter int LOCK_CYC = 512
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       valid,
  input  cmd_e       cmd,
  output logic [1:0] pwr_state,
  output logic       lock_active
);
  localparam int LW = $clog2(LOCK_CYC);

  logic [LW-1:0] lock_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_state <= PWR_ACT;
      lock_cnt  <= '0;
    end else begin
      if (valid) begin
        case (cmd)
          C_PDE:        pwr_state <= PWR_PD;
          C_SRE:        pwr_state <= PWR_SR;
          C_PDX, C_SRX: pwr_state <= PWR_ACT;
          default: ;
        endcase
      end
      if (valid && cmd == C_SRX) lock_cnt <= LW'(LOCK_CYC - 1);
      else if (lock_cnt != '0)   lock_cnt <= lock_cnt - 1'b1;
    end
  end

  assign lock_active = (lock_cnt != '0);
endmodule

// File: rtl/ddr3_burst_track.sv
module ddr3_burst_track
  import ddr3_mon_pkg::*;
#(
  parameter int BURST_CLK = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       mode_load,
  input  logic [1:0] mode_in,
  output logic       busy,
  output logic [1:0] mode
);
  localparam int BW = $clog2(BURST_CLK);

  logic [BW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      mode <= BM_BL8;
    end else begin
      if (start)            cnt <= BW'(BURST_CLK - 1);
      else if (cnt != '0)   cnt <= cnt - 1'b1;
      if (mode_load)        mode <= mode_in;
    end
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/ddr3_cmd_monitor.sv
module ddr3_cmd_monitor
  import ddr3_mon_pkg::*;
#(
  parameter int BA_W      = 3,
  parameter int ADDR_W    = 15,
  parameter int COL_W     = 10,
  parameter int LOCK_CYC  = 512,
  parameter int BURST_CLK = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cke,
  input  logic               cs_n,
  input  logic               ras_n,
  input  logic               cas_n,
  input  logic               we_n,
  input  logic [BA_W-1:0]    ba,
  input  logic [ADDR_W-1:0]  addr,
  output logic               cmd_valid,
  output logic [NUM_CMD-1:0] cmd_onehot,
  output logic [BA_W-1:0]    cmd_bank,
  output logic [ADDR_W-1:0]  cmd_row,
  output logic [COL_W-1:0]   cmd_col,
  output logic               cmd_ap,
  output logic               cmd_len8,
  output logic [1:0]         pwr_state,
  output logic               burst_busy,
  output logic               err_flag,
  output logic [1:0]         err_code
);
  logic cke_prev;
  cmd_e dec_cmd;
  logic dec_valid, dec_illegal;
  logic lock_active, busy_now;
  logic [1:0] bmode;
  logic [NUM_CMD-1:0] oh_d;

  ddr3_cmd_decode u_dec (
    .cke_prev(cke_prev), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .a10(addr[10]), .pwr(pwr_state),
    .cmd(dec_cmd), .valid(dec_valid), .illegal(dec_illegal)
  );

  logic is_rdwr, burst_err, lock_err, mrs0;
  assign is_rdwr   = dec_valid && (dec_cmd == C_RD || dec_cmd == C_WR);
  assign burst_err = is_rdwr && busy_now;
  assign lock_err  = dec_valid && dec_cmd == C_WR && lock_active;
  assign mrs0      = dec_valid && dec_cmd == C_MRS && ba == '0;

  ddr3_pwr_track #(.LOCK_CYC(LOCK_CYC)) u_pwr (
    .clk(clk), .rst(rst), .valid(dec_valid), .cmd(dec_cmd),
    .pwr_state(pwr_state), .lock_active(lock_active)
  );

  ddr3_burst_track #(.BURST_CLK(BURST_CLK)) u_burst (
    .clk(clk), .rst(rst), .start(is_rdwr && !busy_now),
    .mode_load(mrs0), .mode_in(addr[1:0]),
    .busy(busy_now), .mode(bmode)
  );

  for (genvar i = 0; i < NUM_CMD; i++) begin : g_oh
    assign oh_d[i] = dec_valid && (dec_cmd == cmd_e'(i));
  end

  logic len8_d;
  always_comb begin
    case (bmode)
      BM_OTF:  len8_d = addr[12];
      BM_BC4:  len8_d = 1'b0;
      default: len8_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_prev   <= 1'b1;
      cmd_valid  <= 1'b0;
      cmd_onehot <= '0;
      cmd_bank   <= '0;
      cmd_row    <= '0;
      cmd_col    <= '0;
      cmd_ap     <= 1'b0;
      cmd_len8   <= 1'b1;
      err_flag   <= 1'b0;
      err_code   <= ERR_NONE;
    end else begin
      cke_prev   <= cke;
      cmd_valid  <= dec_valid;
      cmd_onehot <= oh_d;
      if (dec_valid) begin
        cmd_bank <= ba;
        cmd_row  <= addr;
        cmd_col  <= addr[COL_W-1:0];
        cmd_ap   <= is_rdwr && addr[10];
        cmd_len8 <= len8_d;
      end
      if (!err_flag && (dec_illegal || burst_err || lock_err)) begin
        err_flag <= 1'b1;
        err_code <= dec_illegal ? ERR_ILLEGAL : (burst_err ? ERR_BURST : ERR_LOCK);
      end
    end
  end

  assign burst_busy = busy_now;
endmodule

// File: rtl/ddr3_cmd_monitor_chk.sv
module ddr3_cmd_monitor_chk
  import ddr3_mon_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               cmd_valid,
  input logic [NUM_CMD-1:0] cmd_onehot,
  input logic [1:0]         pwr_state,
  input logic               burst_busy,
  input logic               err_flag,
  input logic [1:0]         err_code
);
  // R11
  onehot_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $countones(cmd_onehot) == 1);

  // R11
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |-> cmd_onehot == '0);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag && $stable(err_code));

  // R5
  pwr_enc_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_state != 2'b11);

  // R6
  pwr_move_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pwr_state) |-> cmd_valid &&
      (cmd_onehot[C_PDE] || cmd_onehot[C_PDX] || cmd_onehot[C_SRE] || cmd_onehot[C_SRX]));

  // R8
  burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(burst_busy) |=> burst_busy);

  // R10
  err_code_chk: assert property (@(posedge clk) disable iff (rst)
    err_flag |-> err_code != 2'd0);
endmodule

bind ddr3_cmd_monitor ddr3_cmd_monitor_chk u_chk (.*);

// File: tb/sim_ddr3_cmd_monitor.sv
`timescale 1ns/1ps
module sim_ddr3_cmd_monitor;
  import ddr3_mon_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [2:0]  ba = '0;
  logic [14:0] addr = '0;
  logic cmd_valid, cmd_ap, cmd_len8, burst_busy, err_flag;
  logic [14:0] cmd_onehot, cmd_row;
  logic [2:0]  cmd_bank;
  logic [9:0]  cmd_col;
  logic [1:0]  pwr_state, err_code;

  always #2 clk = ~clk;

  ddr3_cmd_monitor u0 (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .cmd_valid(cmd_valid), .cmd_onehot(cmd_onehot),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_ap(cmd_ap),
    .cmd_len8(cmd_len8), .pwr_state(pwr_state), .burst_busy(burst_busy),
    .err_flag(err_flag), .err_code(err_code)
  );

  typedef struct packed {
    logic        valid;
    logic [14:0] oh;
    logic [1:0]  pwr;
    logic        busy;
    logic        ef;
    logic [1:0]  ec;
    logic        rw;
    logic        len8;
    logic        ap;
  } exp_t;

  exp_t  exp_q[$];
  string req_q[$];
  int n_chk = 0, n_fail = 0;

  // reference state, built from the requirements
  logic m_ckep; logic [1:0] m_pwr, m_mode, m_ec; logic m_ef;
  int m_busy, m_lock;

  task automatic model_reset();
    m_ckep = 1'b1; m_pwr = 2'b00; m_mode = 2'b00; m_ef = 1'b0; m_ec = 2'd0;
    m_busy = 0; m_lock = 0;
  endtask

  task automatic step(input logic ck, input logic cs, input logic [2:0] pat,
                      input logic [2:0] b, input logic [14:0] a, input string req);
    exp_t e;
    logic v, ill, rw, berr, lerr;
    int c;
    @(negedge clk);
    cke = ck; cs_n = cs; {ras_n, cas_n, we_n} = pat; ba = b; addr = a;
    v = 1'b0; ill = 1'b0; c = 0;
    if (m_ckep && ck) begin
      v = 1'b1;
      if (cs) c = 1;
      else case (pat)
        3'b000: c = 2;  3'b001: c = 3;  3'b010: c = a[10] ? 8 : 7;
        3'b011: c = 4;  3'b100: c = 6;  3'b101: c = 5;
        3'b110: c = a[10] ? 9 : 10;     default: c = 0;
      endcase
    end else if (m_ckep && !ck) begin
      if (!cs && pat == 3'b001) begin c = 13; v = 1'b1; end
      else if (cs || pat == 3'b111) begin c = 11; v = 1'b1; end
      else ill = 1'b1;
    end else if (!m_ckep && ck) begin
      if (m_pwr == 2'b10) begin c = 14; v = 1'b1; end
      else if (m_pwr == 2'b01) begin c = 12; v = 1'b1; end
      else ill = 1'b1;
    end
    rw   = v && (c == 5 || c == 6);
    berr = rw && m_busy != 0;
    lerr = v && c == 6 && m_lock != 0;
    if (!m_ef && (ill || berr || lerr)) begin
      m_ef = 1'b1; m_ec = ill ? 2'd1 : (berr ? 2'd2 : 2'd3);
    end
    e.len8 = (m_mode == 2'b01) ? a[12] : (m_mode == 2'b10) ? 1'b0 : 1'b1;
    if (rw && !berr) m_busy = 3; else if (m_busy != 0) m_busy--;
    if (v && c == 14) m_lock = 511; else if (m_lock != 0) m_lock--;
    if (v && c == 2 && b == 3'd0) m_mode = a[1:0];
    if (v && c == 11) m_pwr = 2'b01;
    if (v && c == 13) m_pwr = 2'b10;
    if (v && (c == 12 || c == 14)) m_pwr = 2'b00;
    m_ckep = ck;
    e.valid = v; e.oh = v ? (15'd1 << c) : 15'd0; e.pwr = m_pwr;
    e.busy = (m_busy != 0); e.ef = m_ef; e.ec = m_ec; e.rw = rw; e.ap = a[10];
    exp_q.push_back(e); req_q.push_back(req);
  endtask

  task automatic nop(input string req, input logic ck = 1'b1);
    step(ck, 1'b0, 3'b111, 3'd0, 15'd0, req);
  endtask

  task automatic cmd(input logic [2:0] pat, input logic [2:0] b, input logic [14:0] a,
                     input string req);
    step(1'b1, 1'b0, pat, b, a, req);
  endtask

  // monitor: pops one expected item after each edge that follows a drive
  always @(posedge clk) begin
    #1;
    if (exp_q.size() != 0) begin
      exp_t e; string r;
      e = exp_q.pop_front(); r = req_q.pop_front();
      n_chk++;
      if (cmd_valid !== e.valid || cmd_onehot !== e.oh || pwr_state !== e.pwr ||
          burst_busy !== e.busy || err_flag !== e.ef || err_code !== e.ec ||
          (e.rw && (cmd_len8 !== e.len8 || cmd_ap !== e.ap))) begin
        n_fail++;
        $display("FAIL %s: got v=%b oh=%h pwr=%b busy=%b ef=%b ec=%0d len8=%b ap=%b exp v=%b oh=%h pwr=%b busy=%b ef=%b ec=%0d len8=%b ap=%b",
                 r, cmd_valid, cmd_onehot, pwr_state, burst_busy, err_flag, err_code, cmd_len8, cmd_ap,
                 e.valid, e.oh, e.pwr, e.busy, e.ef, e.ec, e.len8, e.ap);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cke = 1'b1; cs_n = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
    n_chk++;
    if (cmd_valid !== 1'b0 || cmd_onehot !== '0 || pwr_state !== 2'b00 ||
        burst_busy !== 1'b0 || err_flag !== 1'b0 || err_code !== 2'd0) begin
      n_fail++;
      $display("FAIL R12: got v=%b oh=%h pwr=%b busy=%b ef=%b ec=%0d exp all zero",
               cmd_valid, cmd_onehot, pwr_state, burst_busy, err_flag, err_code);
    end
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();                                     // R12
    step(1'b1, 1'b1, 3'b101, 3'd0, 15'd0, "R2");   // deselect
    nop("R2");
    cmd(3'b000, 3'd0, 15'd0, "R4");                 // fixed 8-beat
    cmd(3'b011, 3'd2, 15'h1234, "R1");
    cmd(3'b100, 3'd2, 15'h0010, "R4");              // A12 low ignored, len8=1
    nop("R2"); nop("R2"); nop("R8");
    cmd(3'b000, 3'd0, 15'd2, "R4");                 // fixed chop
    cmd(3'b101, 3'd1, 15'h1400, "R4");              // A12 high ignored, len8=0, ap
    repeat (3) nop("R8");
    cmd(3'b000, 3'd0, 15'd1, "R4");                 // on-the-fly
    cmd(3'b101, 3'd1, 15'h0400, "R3");              // len8=0, ap=1
    repeat (3) nop("R8");
    cmd(3'b100, 3'd3, 15'h1000, "R4");              // len8=1
    repeat (3) nop("R8");
    cmd(3'b000, 3'd1, 15'd2, "R4");                 // other bank: mode kept
    cmd(3'b101, 3'd0, 15'h1000, "R4");              // still on-the-fly
    repeat (3) nop("R8");
    cmd(3'b010, 3'd5, 15'h0000, "R3");
    cmd(3'b010, 3'd5, 15'h0400, "R3");
    cmd(3'b001, 3'd0, 15'd0, "R1");
    cmd(3'b110, 3'd0, 15'h0400, "R3");
    cmd(3'b110, 3'd0, 15'h0000, "R3");
    nop("R5", 1'b0);                                // power-down entry
    nop("R5", 1'b0); nop("R5", 1'b0);
    step(1'b1, 1'b1, 3'b000, 3'd0, 15'd0, "R5");   // exit
    step(1'b0, 1'b1, 3'b000, 3'd0, 15'd0, "R5");   // entry with deselect
    step(1'b1, 1'b1, 3'b000, 3'd0, 15'd0, "R5");
    cmd(3'b101, 3'd0, 15'd0, "R8");
    nop("R8"); nop("R8"); nop("R8");
    cmd(3'b101, 3'd0, 15'd0, "R8");                 // 4 edges later: clean
    nop("R2");
    cmd(3'b100, 3'd0, 15'd0, "R8");                 // 2 edges later: error 2
    nop("R8"); nop("R8"); nop("R8");

    do_reset();
    step(1'b0, 1'b0, 3'b001, 3'd0, 15'd0, "R6");   // self-refresh entry
    nop("R6", 1'b0); nop("R6", 1'b0);
    step(1'b1, 1'b1, 3'b111, 3'd0, 15'd0, "R6");   // exit
    cmd(3'b100, 3'd0, 15'd0, "R9");                 // write too soon
    repeat (4) nop("R9");

    do_reset();
    step(1'b0, 1'b0, 3'b001, 3'd0, 15'd0, "R6");
    step(1'b1, 1'b1, 3'b111, 3'd0, 15'd0, "R6");
    repeat (510) nop("R9");
    cmd(3'b100, 3'd0, 15'd0, "R9");                 // 511 edges: error 3
    repeat (4) nop("R9");

    do_reset();
    step(1'b0, 1'b0, 3'b001, 3'd0, 15'd0, "R6");
    step(1'b1, 1'b1, 3'b111, 3'd0, 15'd0, "R6");
    repeat (511) nop("R9");
    cmd(3'b100, 3'd0, 15'd0, "R9");                 // 512 edges: clean
    repeat (4) nop("R9");

    do_reset();
    step(1'b0, 1'b0, 3'b011, 3'd0, 15'd0, "R7");   // fall with activate
    step(1'b1, 1'b1, 3'b111, 3'd0, 15'd0, "R7");   // rise while active
    cmd(3'b101, 3'd0, 15'd0, "R10");
    cmd(3'b101, 3'd0, 15'd0, "R10");                // code stays 1
    repeat (3) nop("R10");

    do_reset();
    step(1'b0, 1'b0, 3'b001, 3'd0, 15'd0, "R6");
    step(1'b1, 1'b1, 3'b111, 3'd0, 15'd0, "R6");
    cmd(3'b101, 3'd0, 15'd0, "R10");
    cmd(3'b100, 3'd0, 15'd0, "R10");                // burst beats lockout: code 2
    repeat (4) nop("R10");

    @(negedge clk); @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule